// File: doc/BRIEF.md
# Shared-Buffer Output Queue Manager

This block manages buffer pointers for a 16-port shared-memory cell switch. Each output port has two pointer queues: a fast one and a slow one. A single free pool hands out buffer addresses. All work happens inside a fixed 32-tick frame. The tick is 0 in the cycle where `frame_sync` is high, and the count then advances by one every cycle. The header of input k is taken at tick 2k. Output k is served at tick 2k+1. Enqueue and dequeue therefore never fall in the same cycle.

An accepted header takes the address at the head of the free pool. That address goes into the chosen class queue of every destination that has room. The block reports it as the shared-memory write address, together with the mask of destinations that received it. For each output slot, the block pops the fast queue if it holds a pointer, and otherwise the slow queue. The popped address is reported as the read address. If both queues are empty, the block raises an idle-cell flag for that port.

A reference count per address records how many queues still hold the address. When the last holder pops it, the address goes back to the tail of the free pool. A cell that wants a buffer but cannot get one counts as a drop.

Top module: `sbq_mgr`

## Requirements
- R1: While `rst_n` is low, all outputs are zero and `drop_count` is zero. After reset the free pool holds every address in ascending order, so the first accepted cell gets address 0, the next gets 1, and so on.
- R2: The tick is 0 in a cycle with `frame_sync` high and advances by one every cycle, modulo 32. The header inputs are used only at even tick 2k, as input k, and are ignored at odd ticks. Output k is served at tick 2k+1. All outputs are registered and show the result in the cycle after the slot, with `rd_port` = k for a served slot and 0 otherwise.
- R3: A header with `hdr_normal`=1 and at least one accepted destination takes the free-pool head. The block then shows `wr_valid`=1, `wr_addr` = that address, and `wr_mask` = the accepted destinations. Otherwise `wr_valid`, `wr_addr` and `wr_mask` are 0.
- R4: A header with `hdr_normal`=0, or with an all-zero `hdr_dest`, takes no address, enqueues nothing and leaves `drop_count` unchanged.
- R5: A multicast header pushes the same address into the queue of every accepted destination. The queue class is fast when `hdr_fast`=1 and slow when `hdr_fast`=0.
- R6: The threshold of output k sits at bits [k*4 +: 4] of `thr_fast` or `thr_slow`. A destination is refused when its queue holds at least that many pointers, or when the queue is full (8). The other destinations in the same mask are still accepted.
- R7: In its slot, an output pops its fast queue if that queue is non-empty, and otherwise its slow queue. Each output pops at most one pointer per frame. The popped pointer appears on `rd_addr` with `rd_valid`=1.
- R8: If both queues of the served output are empty, the block shows `rd_empty`=1 and `rd_valid`=0.
- R9: An address goes back to the tail of the free pool only when the last queue holding it pops it. Addresses are handed out again in the order in which they returned.
- R10: `drop_count` rises by one for each header that has `hdr_normal`=1 and a non-zero mask but gets no address. That happens when every destination is refused or when the free pool is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_sync | input | 1 | Marks tick 0 of a frame |
| hdr_normal | input | 1 | 1 = normal cell, 0 = idle cell |
| hdr_fast | input | 1 | 1 = fast queue class, 0 = slow |
| hdr_dest | input | 16 | Destination output mask |
| thr_fast | input | 64 | Fast-queue thresholds, 4 bits per output |
| thr_slow | input | 64 | Slow-queue thresholds, 4 bits per output |
| wr_valid | output | 1 | Write address issued |
| wr_addr | output | 6 | Buffer address assigned to the cell |
| wr_mask | output | 16 | Destinations that took the pointer |
| rd_valid | output | 1 | Read address issued |
| rd_port | output | 4 | Output served in the previous tick |
| rd_addr | output | 6 | Buffer address to read |
| rd_empty | output | 1 | Served output had nothing queued |
| drop_count | output | 16 | Cells that got no buffer |

## Verification
The assertions take the header inputs as meaningful only at even ticks, and they rely on `frame_sync` to set the tick rather than on any fixed frame position. They also assume that the threshold inputs are quasi-static, since a refusal depends on the threshold value seen in the enqueue cycle. The stimulus changes headers and thresholds only at the falling edge, and it drives random header values on odd ticks to show that these are ignored. It raises `frame_sync` at frame starts and once in the middle of a frame. A reduced pool of 16 addresses lets the traffic exhaust the pool.

// File: rtl/sbq_pkg.sv
// Shared definitions for the queue manager: queue class encoding and
// the mapping from (output, class) to a flat queue index.
package sbq_pkg;
    typedef enum logic {CLS_FAST = 1'b0, CLS_SLOW = 1'b1} sbq_class_e;

    // Flat queue index: fast queue of output p at 2p, slow queue at 2p+1.
    function automatic int qidx(input int port, input sbq_class_e cls);
        return 2 * port + int'(cls);
    endfunction
endpackage

// File: rtl/sbq_frame_timer.sv
// Frame position counter. The sync pulse forces the current tick to 0.
// Assumes the frame length is a power of two, so the counter wraps by overflow.
module sbq_frame_timer #(
    parameter int FRAME = 32,
    localparam int TW = $clog2(FRAME)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_sync,
    output logic [TW-1:0] phase
);
    logic [TW-1:0] tick_q;

    // Current tick: zero under sync, otherwise the running count.
    assign phase = frame_sync ? '0 : tick_q;

    // Advance one tick per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= phase + TW'(1);
    end
endmodule

// File: rtl/sbq_ptr_fifo.sv
// Pointer FIFO with head read-out and an occupancy count.
// PRELOAD=1 fills the FIFO with 0..DEPTH-1 at reset, which is used for the free pool.
// Assumes DEPTH is a power of two, no push when full and no pop when empty.
module sbq_ptr_fifo #(
    parameter int WIDTH   = 6,
    parameter int DEPTH   = 8,
    parameter bit PRELOAD = 1'b0,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic [PW:0]      count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    rd_q, wr_q;
    logic [PW:0]      cnt_q;

    assign head  = mem[rd_q];
    assign count = cnt_q;
    assign empty = (cnt_q == '0);

    // Storage, pointers and count; reset optionally loads the ascending address list.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= PRELOAD ? (PW+1)'(DEPTH) : '0;
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= PRELOAD ? WIDTH'(i) : '0;
        end else begin
            if (push) begin
                mem[wr_q] <= din;
                wr_q      <= wr_q + PW'(1);
            end
            if (pop) rd_q <= rd_q + PW'(1);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + (PW+1)'(1);
                2'b01:   cnt_q <= cnt_q - (PW+1)'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/sbq_refcount.sv
// Count per buffer address of the queues that still hold that address.
// Assumes set and decrement never target the same address in one cycle.
module sbq_refcount #(
    parameter int NADDR = 64,
    parameter int RCW   = 5,
    localparam int AW = $clog2(NADDR)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_en,
    input  logic [AW-1:0]  set_addr,
    input  logic [RCW-1:0] set_val,
    input  logic           dec_en,
    input  logic [AW-1:0]  dec_addr,
    output logic           dec_last
);
    logic [RCW-1:0] cnt_q [NADDR];

    // The holder being removed is the final one.
    assign dec_last = (cnt_q[dec_addr] == RCW'(1));

    // Load on allocation, step down on each dequeue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NADDR; i++) cnt_q[i] <= '0;
        end else begin
            if (set_en) cnt_q[set_addr] <= set_val;
            if (dec_en) cnt_q[dec_addr] <= cnt_q[dec_addr] - RCW'(1);
        end
    end
endmodule

// File: rtl/sbq_mgr.sv
// Shared-buffer output queue manager. Enqueue happens at even ticks
// (input k at tick 2k) and dequeue at odd ticks (output k at tick 2k+1).
// Each output has a fast and a slow pointer queue, and fast is served first.
// Assumes NPORT and NADDR are powers of two.
module sbq_mgr #(
    parameter int NPORT  = 16,
    parameter int NADDR  = 64,
    parameter int QDEPTH = 8,
    parameter int DCW    = 16,
    localparam int FRAME = 2 * NPORT,
    localparam int TW    = $clog2(FRAME),
    localparam int PW    = $clog2(NPORT),
    localparam int AW    = $clog2(NADDR),
    localparam int NQ    = 2 * NPORT,
    localparam int CW    = $clog2(QDEPTH) + 1,
    localparam int RCW   = $clog2(NPORT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              hdr_normal,
    input  logic              hdr_fast,
    input  logic [NPORT-1:0]  hdr_dest,
    input  logic [NPORT*CW-1:0] thr_fast,
    input  logic [NPORT*CW-1:0] thr_slow,
    output logic              wr_valid,
    output logic [AW-1:0]     wr_addr,
    output logic [NPORT-1:0]  wr_mask,
    output logic              rd_valid,
    output logic [PW-1:0]     rd_port,
    output logic [AW-1:0]     rd_addr,
    output logic              rd_empty,
    output logic [DCW-1:0]    drop_count
);
    import sbq_pkg::*;

    logic [TW-1:0]    phase;
    logic [PW-1:0]    slot;
    logic             is_enq, is_deq;
    logic [CW-1:0]    q_count [NQ];
    logic [AW-1:0]    q_head  [NQ];
    logic [NQ-1:0]    q_empty, q_push, q_pop;
    logic [AW-1:0]    pool_head;
    logic             pool_empty;
    logic [AW:0]      pool_count;
    logic [NPORT-1:0] accept_mask;
    logic [RCW-1:0]   accept_cnt;
    logic             do_enq, want_buf, drop_ev;
    logic             fast_rdy, slow_rdy, deq_any, dec_last;
    logic [AW-1:0]    deq_addr;

    sbq_frame_timer #(.FRAME(FRAME)) u_timer (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .phase(phase)
    );

    assign slot   = phase[TW-1:1];
    assign is_enq = ~phase[0];
    assign is_deq =  phase[0];

    // Destinations whose selected-class queue is under both its threshold and its capacity.
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            logic [CW-1:0] occ_f, occ_s;
            logic          room_f, room_s;
            occ_f  = q_count[qidx(p, CLS_FAST)];
            occ_s  = q_count[qidx(p, CLS_SLOW)];
            room_f = (occ_f < thr_fast[p*CW +: CW]) && (occ_f < CW'(QDEPTH));
            room_s = (occ_s < thr_slow[p*CW +: CW]) && (occ_s < CW'(QDEPTH));
            accept_mask[p] = hdr_dest[p] & (hdr_fast ? room_f : room_s);
        end
    end

    // Number of queues that will hold the new address.
    always_comb begin
        accept_cnt = '0;
        for (int p = 0; p < NPORT; p++) accept_cnt += RCW'(accept_mask[p]);
    end

    assign want_buf = is_enq & hdr_normal & (hdr_dest != '0);
    assign do_enq   = want_buf & (accept_mask != '0) & ~pool_empty;
    assign drop_ev  = want_buf & ~do_enq;

    assign fast_rdy = ~q_empty[{slot, 1'b0}];
    assign slow_rdy = ~q_empty[{slot, 1'b1}];
    assign deq_any  = is_deq & (fast_rdy | slow_rdy);
    assign deq_addr = fast_rdy ? q_head[{slot, 1'b0}] : q_head[{slot, 1'b1}];

    // Push and pop strobes for every queue.
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            q_push[qidx(p, CLS_FAST)] = do_enq & accept_mask[p] &  hdr_fast;
            q_push[qidx(p, CLS_SLOW)] = do_enq & accept_mask[p] & ~hdr_fast;
            q_pop[qidx(p, CLS_FAST)]  = is_deq & (slot == PW'(p)) & fast_rdy;
            q_pop[qidx(p, CLS_SLOW)]  = is_deq & (slot == PW'(p)) & ~fast_rdy & slow_rdy;
        end
    end

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        sbq_ptr_fifo #(.WIDTH(AW), .DEPTH(QDEPTH), .PRELOAD(1'b0)) u_q (
            .clk(clk), .rst_n(rst_n),
            .push(q_push[q]), .din(pool_head), .pop(q_pop[q]),
            .head(q_head[q]), .empty(q_empty[q]), .count(q_count[q])
        );
    end

    sbq_ptr_fifo #(.WIDTH(AW), .DEPTH(NADDR), .PRELOAD(1'b1)) u_pool (
        .clk(clk), .rst_n(rst_n),
        .push(deq_any & dec_last), .din(deq_addr), .pop(do_enq),
        .head(pool_head), .empty(pool_empty), .count(pool_count)
    );

    sbq_refcount #(.NADDR(NADDR), .RCW(RCW)) u_refs (
        .clk(clk), .rst_n(rst_n),
        .set_en(do_enq), .set_addr(pool_head), .set_val(accept_cnt),
        .dec_en(deq_any), .dec_addr(deq_addr), .dec_last(dec_last)
    );

    // Registered result of the current slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid   <= 1'b0;
            wr_addr    <= '0;
            wr_mask    <= '0;
            rd_valid   <= 1'b0;
            rd_port    <= '0;
            rd_addr    <= '0;
            rd_empty   <= 1'b0;
            drop_count <= '0;
        end else begin
            wr_valid   <= do_enq;
            wr_addr    <= do_enq ? pool_head : '0;
            wr_mask    <= do_enq ? accept_mask : '0;
            rd_valid   <= deq_any;
            rd_port    <= is_deq ? slot : '0;
            rd_addr    <= deq_any ? deq_addr : '0;
            rd_empty   <= is_deq & ~deq_any;
            drop_count <= drop_count + DCW'(drop_ev);
        end
    end
endmodule

// File: rtl/sbq_mgr_chk.sv
// Temporal checks on the queue manager, attached with bind.
// Assumes that the tick parity shows the slot kind of the previous cycle.
module sbq_mgr_chk #(
    parameter int NPORT = 16,
    parameter int NADDR = 64,
    parameter int DCW   = 16,
    localparam int AW = $clog2(NADDR)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             deq_tick,
    input logic             wr_valid,
    input logic [NPORT-1:0] wr_mask,
    input logic             rd_valid,
    input logic             rd_empty,
    input logic [DCW-1:0]   drop_count,
    input logic [AW:0]      pool_count
);
    // R2: a write result only follows an enqueue tick.
    assert_wr_after_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !$past(deq_tick));
    // R2: a read or idle result only follows a dequeue tick.
    assert_rd_after_odd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || rd_empty) |-> $past(deq_tick));
    // R8: idle flag and read address never appear together.
    assert_rd_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rd_empty));
    // R3: an issued write always reaches at least one destination.
    assert_wr_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_mask != '0));
    // R10: the drop counter grows by at most one per cycle.
    assert_drop_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count == $past(drop_count)) || (drop_count == $past(drop_count) + DCW'(1)));
    // R9: the pool never holds more addresses than exist.
    assert_pool_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pool_count <= (AW+1)'(NADDR));
    // R10: no write is issued together with a drop.
    assert_no_wr_on_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> !wr_valid);
endmodule

bind sbq_mgr sbq_mgr_chk #(.NPORT(NPORT), .NADDR(NADDR), .DCW(DCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .deq_tick(phase[0]),
    .wr_valid(wr_valid), .wr_mask(wr_mask),
    .rd_valid(rd_valid), .rd_empty(rd_empty),
    .drop_count(drop_count), .pool_count(pool_count)
);

// File: tb/sbq_mgr_tb.sv
// Scoreboard bench: the driver models every tick and queues the expected
// registered outputs; the monitor compares them one step after each rising edge.
module sbq_mgr_tb;
    localparam int NP = 16;
    localparam int NA = 16;
    localparam int QD = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_sync = 1'b0;
    logic hdr_normal = 1'b0;
    logic hdr_fast = 1'b0;
    logic [NP-1:0] hdr_dest = '0;
    logic [NP*4-1:0] thr_fast, thr_slow;
    logic wr_valid, rd_valid, rd_empty;
    logic [3:0] wr_addr, rd_addr;
    logic [NP-1:0] wr_mask;
    logic [3:0] rd_port;
    logic [15:0] drop_count;

    always #2.5ns clk = ~clk;

    sbq_mgr #(.NPORT(NP), .NADDR(NA), .QDEPTH(QD), .DCW(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .hdr_normal(hdr_normal), .hdr_fast(hdr_fast), .hdr_dest(hdr_dest),
        .thr_fast(thr_fast), .thr_slow(thr_slow),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_mask(wr_mask),
        .rd_valid(rd_valid), .rd_port(rd_port), .rd_addr(rd_addr),
        .rd_empty(rd_empty), .drop_count(drop_count)
    );

    int thrf [NP];
    int thrs [NP];
    always_comb begin
        for (int k = 0; k < NP; k++) begin
            thr_fast[k*4 +: 4] = 4'(thrf[k]);
            thr_slow[k*4 +: 4] = 4'(thrs[k]);
        end
    end

    typedef struct {
        bit wv; int wa; int wm; bit rv; int rp; int ra; bit re; int dc; string tag;
    } exp_t;
    exp_t expq[$];

    // Reference state kept from the requirements.
    int mq [2*NP][$];
    int pool[$];
    int rc [NA];
    int mtick, mdrop;
    bit hn [NP];
    bit hf [NP];
    int hd [NP];
    string cur_tag;

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        mtick = 0; mdrop = 0; pool.delete();
        for (int a = 0; a < NA; a++) begin pool.push_back(a); rc[a] = 0; end
        for (int q = 0; q < 2*NP; q++) mq[q].delete();
    endtask

    task automatic clear_hdrs();
        for (int k = 0; k < NP; k++) begin hn[k] = 0; hf[k] = 0; hd[k] = 0; end
    endtask

    // Driver: one tick of stimulus plus its expected registered result.
    task automatic run_tick(input bit fs);
        exp_t e;
        int ph, s;
        @(negedge clk);
        ph = fs ? 0 : mtick;
        mtick = (ph + 1) % 32;
        s = ph / 2;
        frame_sync = fs;
        e.wv = 0; e.wa = 0; e.wm = 0; e.rv = 0; e.rp = 0; e.ra = 0; e.re = 0; e.tag = cur_tag;
        if (ph % 2 == 0) begin
            int acc;
            int n;
            hdr_normal = hn[s]; hdr_fast = hf[s]; hdr_dest = NP'(hd[s]);
            acc = 0; n = 0;
            for (int p = 0; p < NP; p++) begin
                int occ, th;
                occ = hf[s] ? mq[2*p].size() : mq[2*p+1].size();
                th  = hf[s] ? thrf[p] : thrs[p];
                if (hd[s][p] && occ < th && occ < QD) begin acc |= (1 << p); n++; end
            end
            if (hn[s] && hd[s] != 0) begin
                if (acc != 0 && pool.size() > 0) begin
                    int a;
                    a = pool.pop_front();
                    rc[a] = n;
                    for (int p = 0; p < NP; p++)
                        if (acc[p]) mq[2*p + (hf[s] ? 0 : 1)].push_back(a);
                    e.wv = 1; e.wa = a; e.wm = acc;
                end else mdrop++;
            end
        end else begin
            // Header lines carry noise at odd ticks; it must be ignored (R2).
            hdr_normal = 1'($urandom); hdr_fast = 1'($urandom); hdr_dest = NP'($urandom);
            e.rp = s;
            if (mq[2*s].size() > 0 || mq[2*s+1].size() > 0) begin
                int a;
                a = (mq[2*s].size() > 0) ? mq[2*s].pop_front() : mq[2*s+1].pop_front();
                e.rv = 1; e.ra = a;
                rc[a]--;
                if (rc[a] == 0) pool.push_back(a);
            end else e.re = 1;
        end
        e.dc = mdrop;
        expq.push_back(e);
    endtask

    task automatic run_frame(input bit sync_first);
        for (int t = 0; t < 32; t++) run_tick(sync_first && t == 0);
    endtask

    // Monitor: compares the outputs produced by the edge just passed.
    always @(posedge clk) begin
        #1ns;
        if (rst_n && expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            check(wr_valid == e.wv, "R3", {e.tag, " wr_valid"}, int'(wr_valid), int'(e.wv));
            check(int'(wr_addr) == e.wa, "R3", {e.tag, " wr_addr"}, int'(wr_addr), e.wa);
            check(int'(wr_mask) == e.wm, "R5", {e.tag, " wr_mask"}, int'(wr_mask), e.wm);
            check(rd_valid == e.rv, "R7", {e.tag, " rd_valid"}, int'(rd_valid), int'(e.rv));
            check(int'(rd_addr) == e.ra, "R7", {e.tag, " rd_addr"}, int'(rd_addr), e.ra);
            check(rd_empty == e.re, "R8", {e.tag, " rd_empty"}, int'(rd_empty), int'(e.re));
            check(int'(rd_port) == e.rp, "R2", {e.tag, " rd_port"}, int'(rd_port), e.rp);
            check(int'(drop_count) == e.dc, "R10", {e.tag, " drop_count"}, int'(drop_count), e.dc);
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 0; hdr_normal = 0; hdr_dest = '0; frame_sync = 0;
        repeat (2) @(negedge clk);
        // R1: reset values at the ports.
        check(!wr_valid && !rd_valid && !rd_empty, "R1", "valid flags in reset", int'({wr_valid, rd_valid, rd_empty}), 0);
        check(drop_count == 0 && wr_addr == 0 && wr_mask == 0 && rd_addr == 0, "R1", "data outputs in reset",
              int'(drop_count) + int'(wr_addr) + int'(wr_mask) + int'(rd_addr), 0);
        model_reset();
        rst_n = 1;
    endtask

    initial begin
        for (int k = 0; k < NP; k++) begin thrf[k] = QD; thrs[k] = QD; end
        clear_hdrs();
        cur_tag = "R1";
        apply_reset();

        // R3: unicast, input k to output (k+3) mod 16, fast class.
        cur_tag = "R3";
        for (int k = 0; k < NP; k++) begin hn[k] = 1; hf[k] = 1; hd[k] = 1 << ((k + 3) % NP); end
        run_frame(1);
        clear_hdrs();
        run_frame(0);

        // R7: slow and fast for output 10 in one frame; fast must be read first.
        cur_tag = "R7";
        hn[0] = 1; hf[0] = 0; hd[0] = 1 << 10;
        hn[1] = 1; hf[1] = 1; hd[1] = 1 << 10;
        hn[2] = 1; hf[2] = 0; hd[2] = 1 << 10;
        run_frame(1);
        clear_hdrs();
        repeat (3) run_frame(0);

        // R5 and R9: multicast to outputs 4..7; the address returns after the last read.
        cur_tag = "R5";
        hn[0] = 1; hf[0] = 1; hd[0] = 'h00F0;
        hn[1] = 1; hf[1] = 0; hd[1] = 'h8001;
        run_frame(1);
        clear_hdrs();
        cur_tag = "R9";
        hn[0] = 1; hf[0] = 1; hd[0] = 1 << 9;
        run_frame(0);
        clear_hdrs();
        run_frame(0);

        // R4: idle cells and an all-zero mask take no address and count no drop.
        cur_tag = "R4";
        for (int k = 0; k < NP; k++) begin hn[k] = 0; hf[k] = 1; hd[k] = 'hFFFF; end
        hn[5] = 1; hd[5] = 0;
        run_frame(1);
        clear_hdrs();

        // R6: slow threshold 1 on output 2, fast threshold 0 on output 4.
        cur_tag = "R6";
        thrs[2] = 1; thrf[4] = 0;
        hn[0] = 1; hf[0] = 0; hd[0] = 1 << 2;
        hn[1] = 1; hf[1] = 0; hd[1] = 1 << 2;
        hn[2] = 1; hf[2] = 0; hd[2] = (1 << 2) | (1 << 3);
        hn[3] = 1; hf[3] = 1; hd[3] = 1 << 4;
        hn[4] = 1; hf[4] = 1; hd[4] = (1 << 4) | (1 << 12);
        run_frame(1);
        clear_hdrs();
        run_frame(0);
        thrs[2] = QD; thrf[4] = QD;

        // R10: every input targets output 0; queue capacity and then the pool run out.
        cur_tag = "R10";
        for (int k = 0; k < NP; k++) begin hn[k] = 1; hf[k] = (k % 2 == 0); hd[k] = 1; end
        repeat (3) run_frame(1);
        for (int k = 0; k < NP; k++) hd[k] = 1 << (k % 3);
        repeat (2) run_frame(0);
        clear_hdrs();
        repeat (18) run_frame(0);

        // R2: realign in mid-frame, then keep traffic running.
        cur_tag = "R2";
        for (int k = 0; k < NP; k++) begin hn[k] = 1; hf[k] = k[0]; hd[k] = 1 << (NP - 1 - k); end
        for (int t = 0; t < 11; t++) run_tick(0);
        run_tick(1);
        for (int t = 0; t < 40; t++) run_tick(0);

        // R9: random traffic and thresholds exercise the address return order.
        cur_tag = "R9";
        for (int f = 0; f < 40; f++) begin
            for (int k = 0; k < NP; k++) begin
                int r;
                r = int'($urandom % 16);
                hn[k] = ($urandom % 4) != 0;
                hf[k] = 1'($urandom);
                hd[k] = (($urandom % 5) == 0) ? ((1 << r) | (1 << ((r + 5) % NP))) : (1 << r);
                if (f % 8 == 0) begin thrf[k] = 1 + int'($urandom % QD); thrs[k] = 1 + int'($urandom % QD); end
            end
            run_frame(1);
        end
        clear_hdrs();
        repeat (10) run_frame(1);

        // R1: reset reloads the pool, so the first address handed out is 0 again.
        @(posedge clk); #2ns;
        cur_tag = "R1";
        apply_reset();
        for (int k = 0; k < NP; k++) begin thrf[k] = QD; thrs[k] = QD; end
        hn[0] = 1; hf[0] = 1; hd[0] = 1 << 6;
        hn[1] = 1; hf[1] = 0; hd[1] = 1 << 6;
        run_frame(1);
        clear_hdrs();
        run_frame(0);
        @(posedge clk); #2ns;
        summary();
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        summary();
    end
endmodule